// File: doc/BRIEF.md
# Conditional Branch Resolver

This unit settles a single conditional branch in one cycle. It takes the condition bit, the four control bits of the branch operand field, the count-test mode bits, the address-form and link bits, a 14-bit word displacement and the current instruction address. From these it produces the branch decision, the next fetch address, and the link-register write strobe with its data. All four are combinational.

The unit holds the 64-bit loop count register. On a clock edge with the valid strobe high, the count register takes its updated value. A load port writes the register directly, in the way a move-to-count instruction does. The count can be tested as zero or nonzero, and it can be decremented unconditionally or only on a particular condition outcome. A further mode bit restricts the link-register write to branches that are actually taken, so that a loop does not overwrite the saved return address.

Branches of this class are prefixed instructions, `INSN_BYTES` (default 8) bytes long. Relative targets are measured from the first byte of the prefix, and the fall-through address is the current address plus the instruction length.

Top module: `branch_resolver`

## Requirements
- R1: After reset, `countQ` reads zero.
- R2: When `countLoad` is high at a clock edge, `countQ` takes `countLoadVal`. The load wins over a decrement requested in the same cycle.
- R3: The condition passes when `condIgnore` is 1 or when `condBit` equals `condSense`. A branch is never taken while the condition fails.
- R4: At a clock edge with `valid` high and no load, the count decrements by one (wrapping modulo 2^64) when `cntSkip` is 0 and the decrement is not cancelled. Otherwise the count holds. Without `valid` or a load it always holds.
- R5: When `cntTest` is 1, the decrement is cancelled whenever the condition outcome (1 = pass) differs from `cntInvert`.
- R6: The count check uses the post-decrement value. It passes when `cntSkip` is 1, or when the count's nonzero status differs from `cntZeroSense` (so `cntZeroSense`=1 asks for a zero count).
- R7: With `wide` low, only bits [31:0] of the count take part in the zero compare. With `wide` high, all 64 bits do.
- R8: `taken` is high exactly when both the count check and the condition pass.
- R9: When taken, `nextAddr` is the displacement sign-extended and shifted left by two. It is used as-is when `absAddr` is 1, and added to `cia` when `absAddr` is 0.
- R10: When not taken, `nextAddr` equals `cia + INSN_BYTES`.
- R11: `linkData` always equals `cia + INSN_BYTES`. `linkWe` is `linkReq` when `linkOnTaken` is 0, and `linkReq AND taken` when `linkOnTaken` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| valid | input | 1 | Branch resolves this cycle; commits the count update |
| countLoad | input | 1 | Direct write of the count register |
| countLoadVal | input | 64 | Value for the direct write |
| condBit | input | 1 | Reduced condition bit |
| condIgnore | input | 1 | Treat the condition as always passing |
| condSense | input | 1 | Value of `condBit` that counts as a pass |
| cntSkip | input | 1 | No decrement and no count check |
| cntZeroSense | input | 1 | 1 means the count check asks for zero |
| cntTest | input | 1 | Make the decrement depend on the condition outcome |
| cntInvert | input | 1 | Condition outcome that allows the decrement under `cntTest` |
| wide | input | 1 | 64-bit mode (1) or 32-bit mode (0) for the count compare |
| absAddr | input | 1 | Displacement is an absolute target |
| linkReq | input | 1 | Link-register update requested |
| linkOnTaken | input | 1 | Update the link register only on a taken branch |
| disp | input | 14 | Word displacement |
| cia | input | 64 | Address of the first byte of the instruction |
| countQ | output | 64 | Count register |
| taken | output | 1 | Branch is taken |
| nextAddr | output | 64 | Next instruction address |
| linkWe | output | 1 | Link register write enable |
| linkData | output | 64 | Value to write to the link register |

## Verification
The hardest situation to reach is a count check that turns on the decrement made in the same cycle. This includes the case where the count crosses zero only in its low 32 bits while the upper half stays nonzero, and the case where a count-test cancel keeps a count of one alive. From reset the count would need on the order of 2^64 steps to reach such values, so the stimulus uses the load port to place counts of one, zero, and 0x1_0000_0001 before the decisive branch. A random phase then mixes frequent small loads with all of the mode bits, and a behavioural model checks every output in every cycle.

// File: rtl/br_pkg.sv
package br_pkg;
  typedef struct packed {
    logic decEn;      // count decrements if committed
    logic takeBranch; // select target address
    logic absTarget;  // target is absolute
    logic linkWr;     // link register write
  } brStrobes_t;
endpackage

// File: rtl/br_control.sv
module br_control
  import br_pkg::*;
(
  input  logic       condBit,
  input  logic       condIgnore,
  input  logic       condSense,
  input  logic       cntSkip,
  input  logic       cntZeroSense,
  input  logic       cntTest,
  input  logic       cntInvert,
  input  logic       absAddr,
  input  logic       linkReq,
  input  logic       linkOnTaken,
  input  logic       nzIfDec,
  input  logic       nzIfHold,
  output brStrobes_t strobes
);
  logic condOk;
  logic decCancel;
  logic decEn;
  logic cntNonZero;
  logic cntOk;
  logic takeIt;

  always_comb begin
    condOk     = condIgnore | ~(condBit ^ condSense);
    decCancel  = cntTest & (condOk ^ cntInvert);
    decEn      = ~cntSkip & ~decCancel;
    cntNonZero = decEn ? nzIfDec : nzIfHold;
    cntOk      = cntSkip | (cntNonZero ^ cntZeroSense);
    takeIt     = cntOk & condOk;
    strobes.decEn      = decEn;
    strobes.takeBranch = takeIt;
    strobes.absTarget  = absAddr;
    strobes.linkWr     = linkReq & (~linkOnTaken | takeIt);
  end
endmodule

// File: rtl/br_datapath.sv
module br_datapath
  import br_pkg::*;
#(
  parameter int ADDR_W     = 64,
  parameter int CNT_W      = 64,
  parameter int NARROW_W   = 32,
  parameter int DISP_W     = 14,
  parameter int INSN_BYTES = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              valid,
  input  logic              countLoad,
  input  logic [CNT_W-1:0]  countLoadVal,
  input  logic              wide,
  input  logic [DISP_W-1:0] disp,
  input  logic [ADDR_W-1:0] cia,
  input  brStrobes_t        strobes,
  output logic              nzIfDec,
  output logic              nzIfHold,
  output logic [CNT_W-1:0]  countQ,
  output logic [ADDR_W-1:0] nextAddr,
  output logic [ADDR_W-1:0] linkData
);
  localparam int OFF_W = DISP_W + 2;
  localparam int EXT_W = ADDR_W - OFF_W;

  logic [CNT_W-1:0]  countDec;
  logic [CNT_W-1:0]  countNext;
  logic [ADDR_W-1:0] offset;
  logic [ADDR_W-1:0] target;
  logic [ADDR_W-1:0] fallThru;

  assign countDec = countQ - CNT_W'(1);

  generate
    if (NARROW_W < CNT_W) begin : g_narrow
      assign nzIfDec  = wide ? (countDec != '0) : (countDec[NARROW_W-1:0] != '0);
      assign nzIfHold = wide ? (countQ   != '0) : (countQ[NARROW_W-1:0]   != '0);
    end else begin : g_full
      assign nzIfDec  = (countDec != '0);
      assign nzIfHold = (countQ   != '0);
    end
  endgenerate

  always_comb begin
    if (countLoad)                  countNext = countLoadVal;
    else if (valid && strobes.decEn) countNext = countDec;
    else                            countNext = countQ;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) countQ <= '0;
    else        countQ <= countNext;
  end

  assign offset   = {{EXT_W{disp[DISP_W-1]}}, disp, 2'b00};
  assign target   = strobes.absTarget ? offset : (cia + offset);
  assign fallThru = cia + ADDR_W'(INSN_BYTES);
  assign nextAddr = strobes.takeBranch ? target : fallThru;
  assign linkData = fallThru;
endmodule

// File: rtl/branch_resolver.sv
module branch_resolver
  import br_pkg::*;
#(
  parameter int ADDR_W     = 64,
  parameter int CNT_W      = 64,
  parameter int NARROW_W   = 32,
  parameter int DISP_W     = 14,
  parameter int INSN_BYTES = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              valid,
  input  logic              countLoad,
  input  logic [CNT_W-1:0]  countLoadVal,
  input  logic              condBit,
  input  logic              condIgnore,
  input  logic              condSense,
  input  logic              cntSkip,
  input  logic              cntZeroSense,
  input  logic              cntTest,
  input  logic              cntInvert,
  input  logic              wide,
  input  logic              absAddr,
  input  logic              linkReq,
  input  logic              linkOnTaken,
  input  logic [DISP_W-1:0] disp,
  input  logic [ADDR_W-1:0] cia,
  output logic [CNT_W-1:0]  countQ,
  output logic              taken,
  output logic [ADDR_W-1:0] nextAddr,
  output logic              linkWe,
  output logic [ADDR_W-1:0] linkData
);
  brStrobes_t strobes;
  logic nzIfDec;
  logic nzIfHold;

  br_control u_ctrl (
    .condBit(condBit), .condIgnore(condIgnore), .condSense(condSense),
    .cntSkip(cntSkip), .cntZeroSense(cntZeroSense), .cntTest(cntTest),
    .cntInvert(cntInvert), .absAddr(absAddr), .linkReq(linkReq),
    .linkOnTaken(linkOnTaken), .nzIfDec(nzIfDec), .nzIfHold(nzIfHold),
    .strobes(strobes)
  );

  br_datapath #(
    .ADDR_W(ADDR_W), .CNT_W(CNT_W), .NARROW_W(NARROW_W),
    .DISP_W(DISP_W), .INSN_BYTES(INSN_BYTES)
  ) u_dp (
    .clk(clk), .rst_n(rst_n), .valid(valid), .countLoad(countLoad),
    .countLoadVal(countLoadVal), .wide(wide), .disp(disp), .cia(cia),
    .strobes(strobes), .nzIfDec(nzIfDec), .nzIfHold(nzIfHold),
    .countQ(countQ), .nextAddr(nextAddr), .linkData(linkData)
  );

  assign taken  = strobes.takeBranch;
  assign linkWe = strobes.linkWr;
endmodule

// File: rtl/branch_resolver_checker.sv
module branch_resolver_checker #(
  parameter int ADDR_W     = 64,
  parameter int CNT_W      = 64,
  parameter int DISP_W     = 14,
  parameter int INSN_BYTES = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              valid,
  input logic              countLoad,
  input logic [CNT_W-1:0]  countLoadVal,
  input logic              condBit,
  input logic              condIgnore,
  input logic              condSense,
  input logic              cntSkip,
  input logic              linkReq,
  input logic              linkOnTaken,
  input logic [ADDR_W-1:0] cia,
  input logic [CNT_W-1:0]  countQ,
  input logic              taken,
  input logic [ADDR_W-1:0] nextAddr,
  input logic              linkWe,
  input logic [ADDR_W-1:0] linkData
);
  p_load_wins_r2: assert property (@(posedge clk) disable iff (!rst_n)
    countLoad |=> countQ == $past(countLoadVal));

  p_idle_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!countLoad && !valid) |=> $stable(countQ));

  p_skip_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!countLoad && cntSkip) |=> $stable(countQ));

  p_cond_gate_r3: assert property (@(posedge clk) disable iff (!rst_n)
    taken |-> (condIgnore || condBit == condSense));

  p_fall_thru_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !taken |-> nextAddr == cia + ADDR_W'(INSN_BYTES));

  p_link_data_r11: assert property (@(posedge clk) disable iff (!rst_n)
    linkData == cia + ADDR_W'(INSN_BYTES));

  p_link_gate_r11: assert property (@(posedge clk) disable iff (!rst_n)
    linkWe |-> (linkReq && (!linkOnTaken || taken)));
endmodule

bind branch_resolver branch_resolver_checker #(
  .ADDR_W(ADDR_W), .CNT_W(CNT_W), .DISP_W(DISP_W), .INSN_BYTES(INSN_BYTES)
) u_chk (
  .clk(clk), .rst_n(rst_n), .valid(valid), .countLoad(countLoad),
  .countLoadVal(countLoadVal), .condBit(condBit), .condIgnore(condIgnore),
  .condSense(condSense), .cntSkip(cntSkip), .linkReq(linkReq),
  .linkOnTaken(linkOnTaken), .cia(cia), .countQ(countQ), .taken(taken),
  .nextAddr(nextAddr), .linkWe(linkWe), .linkData(linkData)
);

// File: tb/test_branch_resolver.sv
module test_branch_resolver;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        valid = 0, countLoad = 0;
  logic [63:0] countLoadVal = '0;
  logic        condBit = 0, condIgnore = 0, condSense = 0;
  logic        cntSkip = 1, cntZeroSense = 0, cntTest = 0, cntInvert = 0;
  logic        wide = 1, absAddr = 0, linkReq = 0, linkOnTaken = 0;
  logic [13:0] disp = '0;
  logic [63:0] cia = '0;
  logic [63:0] countQ, nextAddr, linkData;
  logic        taken, linkWe;

  int tests = 0, fails = 0;
  bit finished = 0;
  logic [63:0] mdlCount = '0;

  always #2 clk = ~clk;

  branch_resolver i_branch_resolver (
    .clk(clk), .rst_n(rst_n), .valid(valid), .countLoad(countLoad),
    .countLoadVal(countLoadVal), .condBit(condBit), .condIgnore(condIgnore),
    .condSense(condSense), .cntSkip(cntSkip), .cntZeroSense(cntZeroSense),
    .cntTest(cntTest), .cntInvert(cntInvert), .wide(wide), .absAddr(absAddr),
    .linkReq(linkReq), .linkOnTaken(linkOnTaken), .disp(disp), .cia(cia),
    .countQ(countQ), .taken(taken), .nextAddr(nextAddr), .linkWe(linkWe),
    .linkData(linkData)
  );

  task automatic check(string req, logic [63:0] act, logic [63:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // One branch: inputs already set after a negedge; compare then commit.
  task automatic step(string focus);
    bit ok, dec, nz, cok, tk, lw;
    logic [63:0] after, off, tgt, fall;
    #1;
    ok    = condIgnore || (condBit == condSense);
    dec   = !cntSkip && !(cntTest && (ok != cntInvert));
    after = dec ? mdlCount - 64'd1 : mdlCount;
    nz    = wide ? (after != 0) : (after[31:0] != 0);
    cok   = cntSkip || (nz != cntZeroSense);
    tk    = cok && ok;
    off   = 64'($signed(disp)) * 64'd4;
    tgt   = absAddr ? off : cia + off;
    fall  = cia + 64'd8;
    lw    = linkReq && (!linkOnTaken || tk);
    check({focus, " R8 taken"}, {63'd0, taken}, {63'd0, tk});
    check(tk ? {focus, " R9 target"} : {focus, " R10 fallthru"}, nextAddr, tk ? tgt : fall);
    check({focus, " R11 linkWe"}, {63'd0, linkWe}, {63'd0, lw});
    check({focus, " R11 linkData"}, linkData, fall);
    @(posedge clk);
    if (countLoad) mdlCount = countLoadVal;
    else if (valid && dec) mdlCount = after;
    @(negedge clk);
    check({focus, countLoad ? " R2 load" : " R4 count"}, countQ, mdlCount);
  endtask

  task automatic setMode(bit ign, bit sense, bit cb, bit skip, bit zs, bit tst, bit inv, bit w);
    condIgnore = ign; condSense = sense; condBit = cb; cntSkip = skip;
    cntZeroSense = zs; cntTest = tst; cntInvert = inv; wide = w;
  endtask

  task automatic load(logic [63:0] v);
    countLoad = 1; countLoadVal = v; valid = 0;
    step("preload");
    countLoad = 0;
  endtask

  initial begin
    #(200000 * 4);
    if (!finished) begin
      tests++; fails++;
      $display("FAIL watchdog: actual hung expected done");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 reset count", countQ, 64'd0);
    rst_n = 1;
    @(negedge clk);
    cia = 64'h0000_0000_0001_0000;

    // R2: load wins over a decrement in the same cycle
    setMode(1, 0, 0, 0, 0, 0, 0, 1);
    valid = 1; countLoad = 1; countLoadVal = 64'd5;
    step("R2 load+valid");
    countLoad = 0;

    // R4: valid decrements; no valid holds
    step("R4 dec");
    valid = 0; step("R4 idle hold");

    // R6: count of one, decrement to zero, zero requested -> taken
    load(64'd1); valid = 1;
    setMode(1, 0, 0, 0, 1, 0, 0, 1); disp = 14'd16; absAddr = 0;
    step("R6 post-dec zero");
    // R4 wrap from zero
    setMode(1, 0, 0, 0, 0, 0, 0, 1); step("R4 wrap");

    // R7: low half crosses zero, upper half nonzero
    load(64'h0000_0001_0000_0001); valid = 1;
    setMode(1, 0, 0, 0, 1, 0, 0, 0); step("R7 narrow zero");
    load(64'h0000_0001_0000_0001); valid = 1;
    setMode(1, 0, 0, 0, 1, 0, 0, 1); step("R7 wide nonzero");

    // R5: count-test cancel keeps count of one
    load(64'd1); valid = 1;
    setMode(0, 1, 1, 0, 0, 1, 0, 1); step("R5 cancel pass");
    setMode(0, 1, 0, 0, 0, 1, 0, 1); step("R5 dec on fail");
    load(64'd3); valid = 1;
    setMode(0, 1, 1, 0, 0, 1, 1, 1); step("R5 inv dec on pass");

    // R3: failing condition blocks branch
    setMode(0, 1, 0, 1, 0, 0, 0, 1); step("R3 cond fail");
    setMode(0, 0, 0, 1, 0, 0, 0, 1); step("R3 cond sense0");

    // R9: negative displacement, relative and absolute
    disp = 14'h3FFF; absAddr = 0; step("R9 neg rel");
    absAddr = 1; disp = 14'h2000; step("R9 neg abs");
    absAddr = 0;

    // R11: link only on taken
    linkReq = 1; linkOnTaken = 1;
    setMode(0, 1, 0, 1, 0, 0, 0, 1); step("R11 lru not taken");
    setMode(0, 1, 1, 1, 0, 0, 0, 1); step("R11 lru taken");
    linkOnTaken = 0;
    setMode(0, 1, 0, 1, 0, 0, 0, 1); step("R11 plain link");

    // Random mix with frequent small loads
    for (int i = 0; i < 600; i++) begin
      countLoad    = ($urandom % 5) == 0;
      countLoadVal = ($urandom % 3 == 0) ? 64'h0000_0001_0000_0000 + 64'($urandom % 3)
                                         : 64'($urandom % 4);
      valid = $urandom % 4 != 0;
      setMode($urandom % 4 == 0, $urandom, $urandom, $urandom % 3 == 0,
              $urandom, $urandom, $urandom, $urandom);
      absAddr = $urandom; linkReq = $urandom; linkOnTaken = $urandom;
      disp = 14'($urandom);
      cia  = {32'($urandom), 32'($urandom)} & ~64'd3;
      step("R8 random");
    end

    finished = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule